// File: doc/BRIEF.md
# Dynamic Bus Sizing Data Steering

This block sits between a processor load/store port and an external memory bus. Each memory area has its own width: 8, 16 or full width. On writes, the processor supplies a byte, halfword or word right-aligned in a 32-bit register. The block places those bytes on the byte lanes that match their address, so the board needs no multiplexers. If the area is narrower than the transfer, the block splits the transfer into several sub-accesses. They go out in a fixed big-endian order, from the highest byte address down. On reads, it collects the bytes from every sub-access. It hands back one right-aligned, zero-extended word, and only once the last sub-access has completed.

Every sub-access has three phases: a one-cycle setup, an access phase that holds a request until the memory side acknowledges it, and a one-cycle hold. On a write, the data-bus output enable covers all three phases. A transfer is launched with a single-cycle start while the block is idle. The block ends it with a one-cycle done pulse, which falls in the hold phase of the last sub-access.

Top module: `bus_sizer`

## Requirements
- R1: After reset, busy, done, rdata_valid, bus_req and bus_oe are low and rdata is zero.
- R2: On a full-width area (area_width 10), a transfer uses a single access with bus_addr_lo 0. Byte address 0, 1, 2 and 3 travel on bus bits 31:24, 23:16, 15:8 and 7:0.
- R3: A written byte or halfword comes from the low bits of wdata, and its least significant byte goes to the highest address it covers. Every lane that carries none of its bytes is driven zero.
- R4: On a 16-bit area (area_width 01), a word takes two accesses. The first has bus_addr_lo 2 and carries bytes 2 and 3 on bits 15:8 and 7:0. The second has bus_addr_lo 0 and carries bytes 0 and 1 on the same lanes.
- R5: On an 8-bit area (area_width 00), a word takes four accesses on bits 7:0, with bus_addr_lo 3, 2, 1 and 0 in that order.
- R6: A byte (xfer_size 00) or halfword (xfer_size 01) on a narrower area uses only the accesses that hold its bytes, highest address first.
- R7: A read returns a right-aligned, zero-extended word (byte address 0 most significant). rdata changes only in the cycle in which rdata_valid is high.
- R8: done is a one-cycle pulse during the hold phase of the last sub-access. rdata_valid pulses with it on reads only.
- R9: Each sub-access has one setup cycle with bus_req low, then bus_req high with bus_addr_lo stable until bus_ack is sampled, then one hold cycle with bus_req low.
- R10: For writes, bus_oe is high through the setup, access and hold phases of every sub-access. For reads, it stays low.
- R11: A start seen while busy is ignored and adds no access.
- R12: area_width 11 and xfer_size 11 behave as full width and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a transfer while idle |
| is_write | input | 1 | 1 = write, 0 = read |
| xfer_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| xfer_addr | input | 2 | Low byte address of the transfer |
| wdata | input | 32 | Right-aligned write data |
| area_width | input | 2 | 00 8-bit, 01 16-bit, 10/11 full width |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completion pulse |
| rdata | output | 32 | Assembled read word |
| rdata_valid | output | 1 | rdata updated this cycle |
| bus_req | output | 1 | Access phase request |
| bus_ack | input | 1 | Memory side completes the access |
| bus_addr_lo | output | 2 | Low address bits of the current sub-access |
| bus_dout | output | DATA_W | Steered write data |
| bus_din | input | DATA_W | Read data from the bus |
| bus_oe | output | 1 | Data-bus drive enable |

## Verification
start is sampled on a clock edge. The sub-access enters setup after that edge, and bus_req is visible one cycle later. Each sub-access takes three cycles plus any ack delay. done and rdata_valid are therefore due n*(3+delay) cycles after the start edge, where n is the number of sub-accesses. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the start edge and requires done on exactly that count. It checks that rdata has not moved on any earlier falling edge. It also counts bus_oe cycles against 3*n for writes.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        logic        wr;
        logic [1:0]  first_b;
        logic [1:0]  last_b;
        logic [2:0]  wbytes;
        logic [2:0]  n_acc;
        logic [1:0]  top_chunk;
        logic [1:0]  cnt;
        logic [31:0] wdata;
        logic [31:0] acc;
        logic [31:0] rdata;
        logic        done;
        logic        rvalid;
    } sizer_state_t;

    // number of bytes in a transfer size code
    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'b00:   size_to_bytes = 3'd1;
            2'b01:   size_to_bytes = 3'd2;
            default: size_to_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bus_sizer_plan.sv
module bus_sizer_plan
    import bus_sizer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0] size_code,
    input  logic [1:0] addr,
    input  logic [1:0] width_code,
    output logic [2:0] wbytes,
    output logic [2:0] n_acc,
    output logic [1:0] last_b,
    output logic [1:0] top_chunk
);
    localparam int         FULL_BYTES = DATA_W / 8;
    localparam logic [2:0] FULL_B3    = 3'(FULL_BYTES);

    logic [2:0] sz;
    logic [2:0] last3;
    logic [1:0] wmask;

    always_comb begin
        sz = size_to_bytes(size_code);
        case (width_code)
            2'b00:   wbytes = 3'd1;
            2'b01:   wbytes = 3'd2;
            default: wbytes = FULL_B3;
        endcase
        // highest byte address touched by the transfer
        last3     = {1'b0, addr} + sz - 3'd1;
        last_b    = last3[1:0];
        // the first sub-access starts at the chunk holding the highest byte
        wmask     = ~(wbytes[1:0] - 2'd1);
        top_chunk = last_b & wmask;
        if (sz <= wbytes)        n_acc = 3'd1;
        else if (wbytes == 3'd1) n_acc = sz;
        else                     n_acc = sz >> 1;
    end

endmodule

// File: rtl/bus_sizer_lanes.sv
module bus_sizer_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        chunk_start,
    input  logic [2:0]        wbytes,
    input  logic [1:0]        first_b,
    input  logic [1:0]        last_b,
    input  logic [31:0]       wdata,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [31:0]       gather
);
    localparam int NLANES = DATA_W / 8;

    logic [NLANES-1:0]   hit_vec;
    logic [2*NLANES-1:0] rsel_flat;

    for (genvar L = 0; L < NLANES; L++) begin : g_lane
        logic [2:0] baddr;
        logic [1:0] rsel;
        // byte address carried by this lane (lane 0 = least significant)
        assign baddr = {1'b0, chunk_start} + wbytes - 3'd1 - 3'(L);
        assign hit_vec[L] = (3'(L) < wbytes) &&
                            (baddr >= {1'b0, first_b}) &&
                            (baddr <= {1'b0, last_b});
        // register byte index: highest address is the least significant byte
        assign rsel = last_b - baddr[1:0];
        assign rsel_flat[2*L +: 2] = rsel;
        assign dout[8*L +: 8] = hit_vec[L] ? wdata[8*rsel +: 8] : 8'h00;
    end

    always_comb begin
        gather = '0;
        for (int L = 0; L < NLANES; L++) begin
            if (hit_vec[L]) gather[8*rsel_flat[2*L +: 2] +: 8] = din[8*L +: 8];
        end
    end

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
    import bus_sizer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [1:0]        xfer_size,
    input  logic [1:0]        xfer_addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        area_width,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              rdata_valid,
    output logic              bus_req,
    input  logic              bus_ack,
    output logic [1:0]        bus_addr_lo,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_oe
);
    sizer_state_t q, d;

    logic [2:0]        p_wb, p_n;
    logic [1:0]        p_last, p_top;
    logic [1:0]        off, chunk_start;
    logic              last_sub;
    logic [DATA_W-1:0] lane_dout;
    logic [31:0]       gather;

    bus_sizer_plan #(.DATA_W(DATA_W)) u_plan (
        .size_code (xfer_size),
        .addr      (xfer_addr),
        .width_code(area_width),
        .wbytes    (p_wb),
        .n_acc     (p_n),
        .last_b    (p_last),
        .top_chunk (p_top)
    );

    always_comb begin
        case (q.wbytes)
            3'd4:    off = q.cnt << 2;
            3'd2:    off = q.cnt << 1;
            default: off = q.cnt;
        endcase
        chunk_start = q.top_chunk - off;
        last_sub    = ({1'b0, q.cnt} == (q.n_acc - 3'd1));
    end

    bus_sizer_lanes #(.DATA_W(DATA_W)) u_lanes (
        .chunk_start(chunk_start),
        .wbytes     (q.wbytes),
        .first_b    (q.first_b),
        .last_b     (q.last_b),
        .wdata      (q.wdata),
        .din        (bus_din),
        .dout       (lane_dout),
        .gather     (gather)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.rvalid = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase     = PH_SETUP;
                    d.wr        = is_write;
                    d.first_b   = xfer_addr;
                    d.last_b    = p_last;
                    d.wbytes    = p_wb;
                    d.n_acc     = p_n;
                    d.top_chunk = p_top;
                    d.cnt       = '0;
                    d.wdata     = wdata;
                    d.acc       = '0;
                end
            end
            PH_SETUP: d.phase = PH_ACCESS;
            PH_ACCESS: begin
                if (bus_ack) begin
                    d.phase = PH_HOLD;
                    if (!q.wr) d.acc = q.acc | gather;
                    if (last_sub) begin
                        d.done = 1'b1;
                        if (!q.wr) begin
                            d.rdata  = q.acc | gather;
                            d.rvalid = 1'b1;
                        end
                    end
                end
            end
            default: begin
                if (last_sub) begin
                    d.phase = PH_IDLE;
                end else begin
                    d.phase = PH_SETUP;
                    d.cnt   = q.cnt + 2'd1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.phase != PH_IDLE);
    assign bus_req     = (q.phase == PH_ACCESS);
    assign bus_oe      = q.wr && busy;
    assign bus_addr_lo = busy ? chunk_start : 2'b00;
    assign bus_dout    = bus_oe ? lane_dout : '0;
    assign done        = q.done;
    assign rdata       = q.rdata;
    assign rdata_valid = q.rvalid;

endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [31:0] rdata,
    input logic        rdata_valid,
    input logic        bus_req,
    input logic        bus_ack,
    input logic [1:0]  bus_addr_lo,
    input logic        bus_oe
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    rvalid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> done);
    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> rdata_valid);
    // R9
    req_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(busy));
    // R9
    req_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr_lo));
    // R9
    hold_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req && busy));
    // R10
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_oe) |=> bus_oe);
    // R10
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> busy);
endmodule

bind bus_sizer bus_sizer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata),
    .rdata_valid(rdata_valid),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_addr_lo(bus_addr_lo),
    .bus_oe     (bus_oe)
);

// File: tb/bus_sizer_bench.sv
`timescale 1ns/1ps
module bus_sizer_bench;
    localparam int DATA_W = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, is_write = 1'b0, bus_ack = 1'b0;
    logic [1:0] xfer_size = '0, xfer_addr = '0, area_width = '0;
    logic [31:0] wdata = '0;
    logic [DATA_W-1:0] bus_din = '0;
    logic busy, done, rdata_valid, bus_req, bus_oe;
    logic [31:0] rdata;
    logic [1:0] bus_addr_lo;
    logic [DATA_W-1:0] bus_dout;

    always #2.5 clk = ~clk;

    bus_sizer #(.DATA_W(DATA_W)) u_bus_sizer (.*);

    int checks = 0, fails = 0;

    // fields: wr, size, addr, width, n, address order (first in 7:6), result
    localparam int NV = 15;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 2'd2, 2'd0, 2'd2, 3'd1, 8'h00, 32'hA1B2C3D4},
        {1'b0, 2'd2, 2'd0, 2'd1, 3'd2, 8'h80, 32'hA1B2C3D4},
        {1'b0, 2'd2, 2'd0, 2'd0, 3'd4, 8'hE4, 32'hA1B2C3D4},
        {1'b0, 2'd0, 2'd1, 2'd2, 3'd1, 8'h00, 32'h000000B2},
        {1'b0, 2'd1, 2'd2, 2'd0, 3'd2, 8'hE0, 32'h0000C3D4},
        {1'b0, 2'd0, 2'd3, 2'd1, 3'd1, 8'h80, 32'h000000D4},
        {1'b0, 2'd1, 2'd0, 2'd1, 3'd1, 8'h00, 32'h0000A1B2},
        {1'b0, 2'd3, 2'd0, 2'd3, 3'd1, 8'h00, 32'hA1B2C3D4},
        {1'b1, 2'd2, 2'd0, 2'd2, 3'd1, 8'h00, 32'h11223344},
        {1'b1, 2'd0, 2'd2, 2'd2, 3'd1, 8'h00, 32'h00004400},
        {1'b1, 2'd1, 2'd0, 2'd0, 3'd2, 8'h40, 32'h33440000},
        {1'b1, 2'd2, 2'd0, 2'd1, 3'd2, 8'h80, 32'h11223344},
        {1'b1, 2'd2, 2'd0, 2'd0, 3'd4, 8'hE4, 32'h11223344},
        {1'b1, 2'd0, 2'd1, 2'd0, 3'd1, 8'h40, 32'h00440000},
        {1'b1, 2'd1, 2'd2, 2'd1, 3'd1, 8'h80, 32'h00003344}
    };

    // results of the last transfer
    int n_seen, done_at, oe_cycles, lane_err, rd_changed, extra_req;
    logic [7:0] addr_seq;
    logic [31:0] result;
    logic rv_seen, done_next;
    logic [7:0] wmem [4];

    function automatic logic [7:0] rmem(input int a);
        case (a)
            0: rmem = 8'hA1;
            1: rmem = 8'hB2;
            2: rmem = 8'hC3;
            default: rmem = 8'hD4;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_xfer(input logic wr, input logic [1:0] sz, input logic [1:0] ad,
                            input logic [1:0] wc, input logic [31:0] wd, input int dly,
                            input bit poke);
        int wb, waitc;
        logic [31:0] prev;
        wb = (wc == 2'd0) ? 1 : (wc == 2'd1) ? 2 : 4;
        for (int i = 0; i < 4; i++) wmem[i] = 8'h00;
        n_seen = 0; done_at = -1; oe_cycles = 0; lane_err = 0; rd_changed = 0;
        addr_seq = '0; result = '0; rv_seen = 0; waitc = 0; extra_req = 0;
        prev = rdata;
        @(negedge clk);
        start = 1'b1; is_write = wr; xfer_size = sz; xfer_addr = ad; area_width = wc; wdata = wd;
        @(posedge clk);
        #1 start = 1'b0;
        for (int c = 1; c < 80; c++) begin
            @(negedge clk);
            if (poke && c == 2) begin start = 1'b1; is_write = 1'b1; end
            if (poke && c == 3) start = 1'b0;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (waitc == dly) begin
                    if (n_seen < 4) addr_seq[7-2*n_seen -: 2] = bus_addr_lo;
                    bus_din = '0;
                    for (int L = 0; L < DATA_W/8; L++) begin
                        int a;
                        a = (int'(bus_addr_lo) / wb) * wb + wb - 1 - L;
                        if (L < wb) begin
                            if (wr) wmem[a] = bus_dout[8*L +: 8];
                            else    bus_din[8*L +: 8] = rmem(a);
                        end else if (bus_dout[8*L +: 8] != 8'h00) begin
                            lane_err++;
                        end
                    end
                    bus_ack = 1'b1;
                    n_seen++;
                    waitc = 0;
                end else begin
                    waitc++;
                end
            end
            if (bus_oe) oe_cycles++;
            if (done) begin
                done_at = c;
                rv_seen = rdata_valid;
                result = wr ? {wmem[0], wmem[1], wmem[2], wmem[3]} : rdata;
                break;
            end
            if (rdata !== prev) rd_changed++;
        end
        @(negedge clk);
        bus_ack = 1'b0;
        done_next = done;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (bus_req || busy) extra_req++;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {30'd0, done, rdata_valid}, 32'd0);
        check("R1 bus", {30'd0, bus_req, bus_oe}, 32'd0);
        check("R1 rdata", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic wr_v;
            logic [1:0] sz_v, ad_v, wc_v;
            logic [2:0] n_v;
            logic [7:0] as_v;
            logic [31:0] res_v;
            string atag;
            {wr_v, sz_v, ad_v, wc_v, n_v, as_v, res_v} = VEC[v];
            run_xfer(wr_v, sz_v, ad_v, wc_v, 32'h11223344, 0, 1'b0);
            atag = (wc_v == 2'd3) ? "R12" :
                   (sz_v < 2'd2 && wc_v < 2'd2) ? "R6" :
                   (wc_v == 2'd2) ? "R2" : (wc_v == 2'd1) ? "R4" : "R5";
            check({atag, " count"}, n_seen, 32'(n_v));
            check({atag, " order"}, {24'd0, addr_seq}, {24'd0, as_v});
            check(wr_v ? "R3 image" : "R7 rdata", result, res_v);
            check("R3 idle lanes", lane_err, 0);
            check("R9 done cycle", done_at, 3 * int'(n_v));
            check("R10 oe cycles", oe_cycles, wr_v ? 3 * int'(n_v) : 0);
            check("R8 rvalid", {31'd0, rv_seen}, {31'd0, !wr_v});
            check("R8 done width", {31'd0, done_next}, 32'd0);
            if (!wr_v) check("R7 early change", rd_changed, 0);
        end

        // R9 slow acknowledge: each access stretched by two cycles
        run_xfer(1'b0, 2'd2, 2'd0, 2'd1, 32'h0, 2, 1'b0);
        check("R9 slow done", done_at, 10);
        check("R9 slow order", {24'd0, addr_seq}, 32'h80);
        check("R7 slow rdata", result, 32'hA1B2C3D4);

        // R11 start while busy must be dropped
        run_xfer(1'b0, 2'd2, 2'd0, 2'd0, 32'hFFFFFFFF, 0, 1'b1);
        check("R11 count", n_seen, 4);
        check("R11 no write oe", oe_cycles, 0);
        check("R11 no extra", extra_req, 0);
        check("R11 rdata", result, 32'hA1B2C3D4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule